// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between one processor port and a shared memory and keeps a single address reservation for that port. A load-linked request reads memory like an ordinary load and records the word address in a link register with a valid flag. A later store-conditional to the same word writes memory only if that reservation is still alive. It then answers 1 for success or 0 for failure in place of the store data.

Write addresses seen on the snoop input come from other processors. Each one is compared with the link register, and a match kills the reservation. Software builds exchange, atomic add and test-and-set out of a load-linked, a modify step and a store-conditional, repeating the loop while the answer is 0. Such a sequence therefore completes only if no other writer touched the word in between. Requests take one cycle, and the response appears on the following cycle.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held and `rsp_valid` is 0. Every accepted request produces exactly one response with `rsp_valid` high on the next cycle.
- R2: `req_op` encodes 0 = load, 1 = store, 2 = load-linked, 3 = store-conditional. A load or load-linked response carries the memory word read at `req_addr`.
- R3: A store-conditional to the linked word, with the reservation valid and no conflicting snoop, writes `req_wdata` to memory and responds with `rsp_data` = 1.
- R4: A store-conditional whose address differs from the link register does not write memory and responds with 0.
- R5: A store-conditional with no preceding load-linked since reset fails with 0 and writes nothing.
- R6: A snooped write to the linked word clears the reservation. A snooped write to any other word leaves it intact.
- R7: When a snoop to the linked word and a store-conditional to it arrive in the same cycle, the snoop wins: the store fails and writes nothing.
- R8: Any store-conditional clears the reservation, so a second store-conditional without a new load-linked fails.
- R9: A new load-linked replaces the reservation with its own address. If a snoop to that same address arrives in the same cycle, the new reservation starts invalid.
- R10: Plain loads and stores reach memory unconditionally, respond with read data and 0 respectively, and do not change the reservation.
- R11: An atomic add written as a load-linked, add, store-conditional retry loop ends with exactly one increment, even when a snooped remote write breaks its first attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request kind (see R2) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| snoop_valid | input | 1 | Remote write observed |
| snoop_addr | input | AW | Word address of remote write |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (combinational) |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DW | Read data, or store-conditional status |

## Verification
A constrained-random stream mixes all four request kinds over eight words. Snoops arrive on about a third of cycles and hit the linked word often. This exposes errors in the address compare, in the clearing of the reservation and in its replacement. Directed cases cover a store-conditional with no reservation, a mismatched address, a snoop in the same cycle as the store-conditional, a snoop in the same cycle as the load-linked, and a repeated store-conditional. These tell apart the reservation's initial state, its priority against snoops, and whether it clears after use. An atomic-add loop with an injected remote write confirms that the retry path yields one increment.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic          link_vld;
  logic [AW-1:0] link_addr;

  wire is_st     = req_valid && req_op == OP_ST;
  wire is_ll     = req_valid && req_op == OP_LL;
  wire is_sc     = req_valid && req_op == OP_SC;
  wire is_rd     = req_valid && (req_op == OP_LD || req_op == OP_LL);
  wire snoop_hit = snoop_valid && link_vld && snoop_addr == link_addr;
  wire sc_ok     = is_sc && link_vld && link_addr == req_addr && !snoop_hit;

  assign mem_we    = is_st || sc_ok;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_vld  <= 1'b0;
      link_addr <= '0;
    end else if (is_ll) begin
      link_addr <= req_addr;
      link_vld  <= !(snoop_valid && snoop_addr == req_addr);
    end else if (is_sc || snoop_hit) begin
      link_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (is_rd)      rsp_data <= mem_rdata;
      else if (is_sc) rsp_data <= {{(DW-1){1'b0}}, sc_ok};
      else            rsp_data <= '0;
    end
  end

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_mismatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && !(link_vld && link_addr == req_addr)) |-> !mem_we);
  a_r7_snoop_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && snoop_valid && snoop_addr == req_addr) |-> !mem_we);
  a_r6_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_addr == link_addr && !is_ll) |=> !link_vld);
  a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> !link_vld);
  a_r3_sc_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> rsp_data[DW-1:1] == '0);
endmodule

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int AW = 8, DW = 32;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0; logic [DW-1:0] req_wdata = 0;
  logic snoop_valid = 0; logic [AW-1:0] snoop_addr = 0;
  logic mem_we; logic [AW-1:0] mem_addr; logic [DW-1:0] mem_wdata, mem_rdata;
  logic rsp_valid; logic [DW-1:0] rsp_data;
  logic [DW-1:0] ram [0:(1<<AW)-1];
  logic remote_wr = 0; logic [DW-1:0] remote_data = 0;

  int checks = 0, failures = 0;
  logic [DW-1:0] m_mem [0:(1<<AW)-1];
  logic m_vld = 0; logic [AW-1:0] m_addr = 0;
  logic [DW-1:0] got_d; logic got_v;

  always #4 clk = ~clk;

  llsc_monitor #(.AW(AW), .DW(DW)) u_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data));

  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) begin
    if (remote_wr && snoop_valid) ram[snoop_addr] <= remote_data;
    if (mem_we) ram[mem_addr] <= mem_wdata;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] wd, input logic sv, input logic [AW-1:0] sa);
    logic hit, ok; logic [DW-1:0] r;
    hit = sv && m_vld && sa == m_addr;
    ok  = op == 2'd3 && m_vld && m_addr == a && !hit;
    r = '0;
    case (op)
      2'd0: r = m_mem[a];
      2'd1: m_mem[a] = wd;
      2'd2: begin r = m_mem[a]; m_addr = a; m_vld = !(sv && sa == a); end
      default: begin r = {31'b0, ok}; if (ok) m_mem[a] = wd; m_vld = 0; end
    endcase
    if (op != 2'd2 && hit) m_vld = 0;
    return r;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
      input logic sv, input logic [AW-1:0] sa);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = wd;
    snoop_valid = sv; snoop_addr = sa;
    @(negedge clk);
    got_v = rsp_valid; got_d = rsp_data;
    req_valid = 0; snoop_valid = 0; remote_wr = 0;
  endtask

  task automatic step(input string req, input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] wd, input logic sv, input logic [AW-1:0] sa);
    logic [DW-1:0] e;
    e = model(op, a, wd, sv, sa);
    issue(op, a, wd, sv, sa);
    check({req, " R1 rsp_valid"}, {31'b0, got_v}, 1);
    check(req, got_d, e);
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tries; logic [DW-1:0] v, e;
    for (int i = 0; i < (1<<AW); i++) begin ram[i] = i * 3 + 7; m_mem[i] = i * 3 + 7; end
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", {31'b0, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    step("R5 sc without ll", 2'd3, 8'd4, 32'hAAAA, 0, 0);
    step("R5 mem untouched", 2'd0, 8'd4, 0, 0, 0);
    step("R2 ll data", 2'd2, 8'd5, 0, 0, 0);
    step("R4 sc mismatch", 2'd3, 8'd6, 32'hBEEF, 0, 0);
    step("R4 mem untouched", 2'd0, 8'd6, 0, 0, 0);
    step("R2 ll", 2'd2, 8'd5, 0, 0, 0);
    step("R6 snoop other addr keeps", 2'd0, 8'd1, 0, 1, 8'd9);
    step("R3 sc success", 2'd3, 8'd5, 32'h1234, 0, 0);
    step("R3 mem written", 2'd0, 8'd5, 0, 0, 0);
    step("R8 second sc fails", 2'd3, 8'd5, 32'h5555, 0, 0);
    step("R2 ll", 2'd2, 8'd7, 0, 0, 0);
    step("R10 store other keeps", 2'd1, 8'd2, 32'h77, 0, 0);
    step("R7 same-cycle snoop", 2'd3, 8'd7, 32'h99, 1, 8'd7);
    step("R7 mem untouched", 2'd0, 8'd7, 0, 0, 0);
    step("R2 ll", 2'd2, 8'd3, 0, 0, 0);
    step("R6 snoop clears", 2'd0, 8'd0, 0, 1, 8'd3);
    step("R6 sc after snoop fails", 2'd3, 8'd3, 32'h11, 0, 0);
    step("R9 ll a", 2'd2, 8'd1, 0, 0, 0);
    step("R9 ll b replaces", 2'd2, 8'd2, 0, 0, 0);
    step("R9 sc old addr fails", 2'd3, 8'd1, 32'h22, 0, 0);
    step("R9 ll with snoop", 2'd2, 8'd2, 0, 1, 8'd2);
    step("R9 sc after snooped ll fails", 2'd3, 8'd2, 32'h33, 0, 0);
    step("R10 store", 2'd1, 8'd0, 32'hCAFE, 0, 0);
    step("R10 load", 2'd0, 8'd0, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] op; logic [AW-1:0] a, sa; logic sv;
      op = 2'($urandom_range(0, 3));
      a  = 8'($urandom_range(0, 7));
      sv = $urandom_range(0, 2) == 0;
      sa = ($urandom_range(0, 1) == 0) ? m_addr : 8'($urandom_range(0, 7));
      step("R2 R3 R4 R6 R10 random", op, a, $urandom, sv, sa);
    end

    // R11: atomic add loop, first attempt broken by a remote write
    step("R11 setup", 2'd1, 8'd10, 32'd100, 0, 0);
    tries = 0;
    e = 32'd200 + 32'd1;
    forever begin
      tries++;
      issue(2'd2, 8'd10, 0, 0, 0);
      v = got_d;
      if (tries == 1) begin
        remote_wr = 1; remote_data = 32'd200;
        issue(2'd0, 8'd11, 0, 1, 8'd10);
      end
      issue(2'd3, 8'd10, v + 1, 0, 0);
      if (got_d == 1 || tries > 4) break;
    end
    check("R11 retry count", tries, 2);
    issue(2'd0, 8'd10, 0, 0, 0);
    check("R11 final value", got_d, e);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule